// File: doc/BRIEF.md
# Tag-Renaming Reservation Station Group with Result Broadcast Bus

This block is the out-of-order scheduling core of an execution cluster. It holds a small pool of reservation stations split between an adder/subtractor unit and a multiplier unit, a register file with one status entry per register, and a single result bus. When an instruction issues, it takes the lowest-numbered free station of the right type. Each source operand is either copied as a value or recorded as the tag of the station that will produce it. The destination register's status entry then takes the new station's tag. This renaming removes write-after-read and write-after-write hazards without any stall.

Each station watches the result bus. It takes a value only when the broadcast tag equals the tag it is waiting for. Once both operands are present, it asks its unit to execute. Each functional unit is a fixed-latency pipeline. A finished result waits at the pipeline output until it wins the bus. Only one result is broadcast per cycle, and the result that has waited longest goes first. A broadcast writes every register whose status entry still names the producer and frees the producing station.

A read port shows any register's value and status tag, so the architectural state can be observed.

Top module: `rsv_cdb_sched`

## Requirements
- R1: After reset, register r holds the value r and status tag 0. No broadcast is active, and issue is possible for every kind.
- R2: `iss_ready` is low while every station of the type needed by `iss_kind` is busy. An `iss_valid` pulse in that state leaves the destination's status tag unchanged.
- R3: Adder stations carry tags 1..N_ADD and multiplier stations carry tags N_ADD+1..N_ADD+N_MUL. Issue takes the lowest-numbered free station of the needed type. In the next cycle, the destination register's status tag equals that station's tag.
- R4: Register contents after all pending results are broadcast equal those of strict program-order execution, whatever the read-after-write, write-after-read and write-after-write patterns. A broadcast updates a register only while that register's status tag equals the broadcast tag, so a newer renaming is never overwritten.
- R5: An instruction whose operands are ready at issue, with an idle unit and a free bus, is broadcast exactly LAT cycles after its issue cycle (ADD_LAT or MUL_LAT). A station waiting on an operand does not dispatch before capturing it, and it is broadcast LAT+1 cycles after its producer's broadcast.
- R6: The bus carries DATA_W (64) bits of data and a TAG_W (4) bit producer tag, which is never 0 while valid. Products keep their low 64 bits, and differences wrap modulo 2^64.
- R7: If an operand's producer is broadcasting in the very cycle the consumer issues, the consumer captures the value at issue and does not wait.
- R8: A station becomes free the cycle after its result is broadcast, and its tag is reused by the next allocation of that type.
- R9: At most one result is broadcast per cycle. Among waiting unit outputs, the one that has waited the most cycles wins. On a tie, the adder unit wins.
- R10: `iss_kind` encoding: 0 adds, 1 subtracts (src1 minus src2), and 2 and 3 both multiply on the multiplier unit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Issue request |
| iss_kind | input | 2 | Operation kind (R10) |
| iss_dst | input | RA_W (3) | Destination register |
| iss_src1 | input | RA_W (3) | First source register |
| iss_src2 | input | RA_W (3) | Second source register |
| iss_ready | output | 1 | A station of the needed type is free |
| rd_addr | input | RA_W (3) | Observation read address |
| rd_data | output | DATA_W (64) | Value of register `rd_addr` |
| rd_tag | output | TAG_W (4) | Status tag of register `rd_addr` (0 = valid) |
| cdb_valid | output | 1 | Result bus carries a result |
| cdb_tag | output | TAG_W (4) | Producing station tag |
| cdb_data | output | DATA_W (64) | Result value |

## Verification
The assertions assume that an issue is only counted when `iss_valid` and `iss_ready` are both high. They also assume that the register indices are always within range, which holds by width. The bench drives issue only on the falling edge and waits on `iss_ready` unless a test deliberately probes a stall. Before timing-sensitive scenarios it lets all previous work drain, so that station numbering and bus contention start from a known idle state. A reference register image is updated in program order at each accepted issue and compared with the read port after each drain.

// File: rtl/rsv_pkg.sv
package rsv_pkg;
   typedef enum logic [1:0] {
      OPK_ADD  = 2'd0,
      OPK_SUB  = 2'd1,
      OPK_MUL  = 2'd2,
      OPK_MULX = 2'd3
   } opk_e;

   function automatic logic opk_uses_mul(input logic [1:0] k);
      return k[1];
   endfunction
endpackage

// File: rtl/rsv_fu_pipe.sv
module rsv_fu_pipe #(
   parameter int LAT    = 2,
   parameter int DATA_W = 64,
   parameter int TAG_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [TAG_W-1:0]  in_tag,
   input  logic [DATA_W-1:0] in_data,
   input  logic              grant,
   output logic              in_ready,
   output logic              out_valid,
   output logic [TAG_W-1:0]  out_tag,
   output logic [DATA_W-1:0] out_data
);
   logic [LAT-1:0]    vld;
   logic [TAG_W-1:0]  tg [LAT];
   logic [DATA_W-1:0] dt [LAT];

   // whole pipe freezes while its finished result waits for the bus
   assign in_ready  = !(vld[LAT-1] && !grant);
   assign out_valid = vld[LAT-1];
   assign out_tag   = tg[LAT-1];
   assign out_data  = dt[LAT-1];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld <= '0;
      end else if (in_ready) begin
         vld[0] <= in_valid;
         for (int s = 1; s < LAT; s++) vld[s] <= vld[s-1];
      end
   end

   always_ff @(posedge clk) begin
      if (in_ready) begin
         tg[0] <= in_tag;
         dt[0] <= in_data;
         for (int s = 1; s < LAT; s++) begin
            tg[s] <= tg[s-1];
            dt[s] <= dt[s-1];
         end
      end
   end
endmodule

// File: rtl/rsv_cdb_arb.sv
module rsv_cdb_arb #(
   parameter int NU    = 2,
   parameter int AGE_W = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [NU-1:0] req,
   output logic [NU-1:0] grant
);
   localparam logic [AGE_W-1:0] AGE_MAX = '1;
   logic [AGE_W-1:0] age [NU];

   always_comb begin
      int best;
      logic any;
      best  = 0;
      any   = 1'b0;
      grant = '0;
      for (int u = 0; u < NU; u++) begin
         if (req[u] && (!any || age[u] > age[best])) begin
            best = u;
            any  = 1'b1;
         end
      end
      if (any) grant[best] = 1'b1;
   end

   always_ff @(posedge clk) begin
      for (int u = 0; u < NU; u++) begin
         if (!rst_n || !req[u] || grant[u]) age[u] <= '0;
         else if (age[u] != AGE_MAX)        age[u] <= age[u] + 1'b1;
      end
   end
endmodule

// File: rtl/rsv_slot.sv
module rsv_slot #(
   parameter int DATA_W = 64,
   parameter int TAG_W  = 4,
   parameter int MY_TAG = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alloc,
   input  logic [1:0]        alloc_op,
   input  logic [DATA_W-1:0] alloc_v1,
   input  logic [TAG_W-1:0]  alloc_q1,
   input  logic [DATA_W-1:0] alloc_v2,
   input  logic [TAG_W-1:0]  alloc_q2,
   input  logic              disp,
   input  logic              cdb_valid,
   input  logic [TAG_W-1:0]  cdb_tag,
   input  logic [DATA_W-1:0] cdb_data,
   output logic              busy,
   output logic              ready,
   output logic [1:0]        op,
   output logic [DATA_W-1:0] v1,
   output logic [DATA_W-1:0] v2
);
   logic [TAG_W-1:0] q1, q2;
   logic             exec;
   logic             mine;

   assign mine  = cdb_valid && (cdb_tag == TAG_W'(MY_TAG));
   assign ready = busy && !exec && (q1 == '0) && (q2 == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy <= 1'b0;
         exec <= 1'b0;
         op   <= '0;
         v1   <= '0;
         v2   <= '0;
         q1   <= '0;
         q2   <= '0;
      end else if (alloc) begin
         busy <= 1'b1;
         exec <= 1'b0;
         op   <= alloc_op;
         v1   <= alloc_v1;
         q1   <= alloc_q1;
         v2   <= alloc_v2;
         q2   <= alloc_q2;
      end else if (busy) begin
         if (mine) begin
            busy <= 1'b0;
            exec <= 1'b0;
         end else begin
            if (disp) exec <= 1'b1;
            if (cdb_valid && q1 != '0 && q1 == cdb_tag) begin
               v1 <= cdb_data;
               q1 <= '0;
            end
            if (cdb_valid && q2 != '0 && q2 == cdb_tag) begin
               v2 <= cdb_data;
               q2 <= '0;
            end
         end
      end
   end
endmodule

// File: rtl/rsv_cdb_sched.sv
module rsv_cdb_sched #(
   parameter int DATA_W  = 64,
   parameter int TAG_W   = 4,
   parameter int NREG    = 8,
   parameter int N_ADD   = 3,
   parameter int N_MUL   = 2,
   parameter int ADD_LAT = 2,
   parameter int MUL_LAT = 4,
   parameter int AGE_W   = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      iss_valid,
   input  logic [1:0]                iss_kind,
   input  logic [$clog2(NREG)-1:0]   iss_dst,
   input  logic [$clog2(NREG)-1:0]   iss_src1,
   input  logic [$clog2(NREG)-1:0]   iss_src2,
   output logic                      iss_ready,
   input  logic [$clog2(NREG)-1:0]   rd_addr,
   output logic [DATA_W-1:0]         rd_data,
   output logic [TAG_W-1:0]          rd_tag,
   output logic                      cdb_valid,
   output logic [TAG_W-1:0]          cdb_tag,
   output logic [DATA_W-1:0]         cdb_data
);
   localparam int NS   = N_ADD + N_MUL;
   localparam int RA_W = $clog2(NREG);
   localparam int NU   = 2;

   if (NS > (2**TAG_W) - 1) begin : g_err_tag
      $error("rsv_cdb_sched: TAG_W too narrow for the station count");
   end
   if (N_ADD < 1 || N_MUL < 1) begin : g_err_cnt
      $error("rsv_cdb_sched: each unit needs at least one station");
   end
   if (ADD_LAT < 1 || MUL_LAT < 1) begin : g_err_lat
      $error("rsv_cdb_sched: latencies must be at least 1");
   end
   if (NREG < 2 || (2**RA_W) != NREG) begin : g_err_reg
      $error("rsv_cdb_sched: NREG must be a power of two, at least 2");
   end

   logic [DATA_W-1:0]           reg_val [NREG];
   logic [NREG-1:0][TAG_W-1:0]  reg_tag;

   logic [NS-1:0]     st_busy, st_ready, st_alloc, st_disp;
   logic [1:0]        st_op [NS];
   logic [DATA_W-1:0] st_v1 [NS];
   logic [DATA_W-1:0] st_v2 [NS];
   logic [NS-1:0]     disp_u [NU];

   logic              iss_fire;
   logic [TAG_W-1:0]  new_tag;
   logic [DATA_W-1:0] a_v1, a_v2;
   logic [TAG_W-1:0]  a_q1, a_q2, t1, t2;

   logic [NU-1:0]     fu_ovld, fu_iready, fu_ivld, arb_grant;
   logic [TAG_W-1:0]  fu_otag [NU];
   logic [DATA_W-1:0] fu_odata [NU];

   assign rd_data = reg_val[rd_addr];
   assign rd_tag  = reg_tag[rd_addr];

   // lowest free station of the needed type
   always_comb begin
      logic want_mul;
      logic found;
      want_mul = rsv_pkg::opk_uses_mul(iss_kind);
      found    = 1'b0;
      st_alloc = '0;
      new_tag  = '0;
      for (int i = 0; i < NS; i++) begin
         if (!found && !st_busy[i] && ((i >= N_ADD) == want_mul)) begin
            found       = 1'b1;
            st_alloc[i] = iss_valid;
            new_tag     = TAG_W'(i + 1);
         end
      end
      iss_ready = found;
   end
   assign iss_fire = iss_valid && iss_ready;

   // operand capture at issue, with same-cycle bus bypass
   always_comb begin
      t1 = reg_tag[iss_src1];
      t2 = reg_tag[iss_src2];
      if (t1 == '0) begin
         a_v1 = reg_val[iss_src1]; a_q1 = '0;
      end else if (cdb_valid && cdb_tag == t1) begin
         a_v1 = cdb_data;          a_q1 = '0;
      end else begin
         a_v1 = '0;                a_q1 = t1;
      end
      if (t2 == '0) begin
         a_v2 = reg_val[iss_src2]; a_q2 = '0;
      end else if (cdb_valid && cdb_tag == t2) begin
         a_v2 = cdb_data;          a_q2 = '0;
      end else begin
         a_v2 = '0;                a_q2 = t2;
      end
   end

   // register file and status table
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int r = 0; r < NREG; r++) begin
            reg_val[r] <= DATA_W'(r);
            reg_tag[r] <= '0;
         end
      end else begin
         for (int r = 0; r < NREG; r++) begin
            if (cdb_valid && reg_tag[r] != '0 && reg_tag[r] == cdb_tag) begin
               reg_val[r] <= cdb_data;
               reg_tag[r] <= '0;
            end
            if (iss_fire && iss_dst == RA_W'(r)) reg_tag[r] <= new_tag;
         end
      end
   end

   for (genvar i = 0; i < NS; i++) begin : g_slot
      rsv_slot #(.DATA_W(DATA_W), .TAG_W(TAG_W), .MY_TAG(i + 1)) u_slot (
         .clk      (clk),
         .rst_n    (rst_n),
         .alloc    (st_alloc[i]),
         .alloc_op (iss_kind),
         .alloc_v1 (a_v1),
         .alloc_q1 (a_q1),
         .alloc_v2 (a_v2),
         .alloc_q2 (a_q2),
         .disp     (st_disp[i]),
         .cdb_valid(cdb_valid),
         .cdb_tag  (cdb_tag),
         .cdb_data (cdb_data),
         .busy     (st_busy[i]),
         .ready    (st_ready[i]),
         .op       (st_op[i]),
         .v1       (st_v1[i]),
         .v2       (st_v2[i])
      );
   end

   for (genvar U = 0; U < NU; U++) begin : g_unit
      localparam int LO  = (U == 0) ? 0 : N_ADD;
      localparam int CNT = (U == 0) ? N_ADD : N_MUL;
      localparam int LAT = (U == 0) ? ADD_LAT : MUL_LAT;

      logic [NS-1:0]     pick;
      logic              any;
      logic [1:0]        sel_op;
      logic [DATA_W-1:0] sel_v1, sel_v2, res;
      logic [TAG_W-1:0]  sel_tag;

      always_comb begin
         pick    = '0;
         any     = 1'b0;
         sel_op  = '0;
         sel_v1  = '0;
         sel_v2  = '0;
         sel_tag = '0;
         for (int i = LO; i < LO + CNT; i++) begin
            if (!any && st_ready[i]) begin
               any     = 1'b1;
               pick[i] = fu_iready[U];
               sel_op  = st_op[i];
               sel_v1  = st_v1[i];
               sel_v2  = st_v2[i];
               sel_tag = TAG_W'(i + 1);
            end
         end
      end
      assign disp_u[U]  = pick;
      assign fu_ivld[U] = any;

      if (U == 0) begin : g_addsub
         assign res = (sel_op == 2'(rsv_pkg::OPK_SUB)) ? sel_v1 - sel_v2
                                                       : sel_v1 + sel_v2;
      end else begin : g_mul
         assign res = sel_v1 * sel_v2;
      end

      rsv_fu_pipe #(.LAT(LAT), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_pipe (
         .clk      (clk),
         .rst_n    (rst_n),
         .in_valid (fu_ivld[U]),
         .in_tag   (sel_tag),
         .in_data  (res),
         .grant    (arb_grant[U]),
         .in_ready (fu_iready[U]),
         .out_valid(fu_ovld[U]),
         .out_tag  (fu_otag[U]),
         .out_data (fu_odata[U])
      );
   end

   assign st_disp = disp_u[0] | disp_u[1];

   rsv_cdb_arb #(.NU(NU), .AGE_W(AGE_W)) u_arb (
      .clk  (clk),
      .rst_n(rst_n),
      .req  (fu_ovld),
      .grant(arb_grant)
   );

   always_comb begin
      cdb_valid = |arb_grant;
      cdb_tag   = '0;
      cdb_data  = '0;
      for (int u = 0; u < NU; u++) begin
         if (arb_grant[u]) begin
            cdb_tag  = fu_otag[u];
            cdb_data = fu_odata[u];
         end
      end
   end
endmodule

// File: rtl/rsv_cdb_sched_chk.sv
module rsv_cdb_sched_chk #(
   parameter int NS    = 5,
   parameter int TAG_W = 4,
   parameter int NREG  = 8,
   parameter int RA_W  = 3
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     iss_valid,
   input logic                     iss_ready,
   input logic [RA_W-1:0]          iss_dst,
   input logic                     cdb_valid,
   input logic [TAG_W-1:0]         cdb_tag,
   input logic [NS-1:0]            st_busy,
   input logic [NREG-1:0][TAG_W-1:0] reg_tag,
   input logic [1:0]               arb_grant
);
   p_tag_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cdb_valid |-> (cdb_tag != '0 && cdb_tag <= TAG_W'(NS)));

   p_one_bcast_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(arb_grant));

   p_stall_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_valid && !iss_ready) |=> ($countones(st_busy) <= $past($countones(st_busy))));

   p_rename_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_valid && iss_ready) |=> (reg_tag[$past(iss_dst)] != '0));

   for (genvar t = 1; t <= NS; t++) begin : g_st
      p_bcast_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (cdb_valid && cdb_tag == TAG_W'(t)) |-> st_busy[t-1]);
      p_free_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (cdb_valid && cdb_tag == TAG_W'(t)) |=> !st_busy[t-1]);
   end

   for (genvar r = 0; r < NREG; r++) begin : g_rg
      p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (cdb_valid && reg_tag[r] == cdb_tag &&
          !(iss_valid && iss_ready && iss_dst == RA_W'(r))) |=> (reg_tag[r] == '0));
   end
endmodule

bind rsv_cdb_sched rsv_cdb_sched_chk #(
   .NS(NS), .TAG_W(TAG_W), .NREG(NREG), .RA_W(RA_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .iss_valid(iss_valid),
   .iss_ready(iss_ready),
   .iss_dst  (iss_dst),
   .cdb_valid(cdb_valid),
   .cdb_tag  (cdb_tag),
   .st_busy  (st_busy),
   .reg_tag  (reg_tag),
   .arb_grant(arb_grant)
);

// File: tb/sim_rsv_cdb_sched.sv
`timescale 1ns/1ps
module sim_rsv_cdb_sched;
   localparam int ADD_LAT = 2;
   localparam int MUL_LAT = 4;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        iss_valid;
   logic [1:0]  iss_kind;
   logic [2:0]  iss_dst, iss_src1, iss_src2, rd_addr;
   logic        iss_ready;
   logic [63:0] rd_data, cdb_data;
   logic [3:0]  rd_tag, cdb_tag;
   logic        cdb_valid;

   int checks = 0, failures = 0, cyc = 0;
   bit done = 0;
   logic [63:0] model [8];
   int last_bc [16];

   always #2 clk = ~clk;

   rsv_cdb_sched #(.ADD_LAT(ADD_LAT), .MUL_LAT(MUL_LAT)) u0 (
      .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_kind(iss_kind),
      .iss_dst(iss_dst), .iss_src1(iss_src1), .iss_src2(iss_src2),
      .iss_ready(iss_ready), .rd_addr(rd_addr), .rd_data(rd_data),
      .rd_tag(rd_tag), .cdb_valid(cdb_valid), .cdb_tag(cdb_tag),
      .cdb_data(cdb_data));

   always @(posedge clk) cyc++;
   always @(negedge clk) if (rst_n && cdb_valid) last_bc[cdb_tag] = cyc;

   task automatic check(input bit ok, input string req, input string what,
                        input longint unsigned act, input longint unsigned exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic clear_log();
      for (int t = 0; t < 16; t++) last_bc[t] = -1;
   endtask

   task automatic read_reg(input int a, output logic [63:0] v, output logic [3:0] t);
      rd_addr = 3'(a);
      #1;
      v = rd_data;
      t = rd_tag;
      @(negedge clk);
   endtask

   // issue at the next rising edge that allows it; returns on the falling edge after
   task automatic do_issue(input logic [1:0] k, input int d, input int s1, input int s2);
      int guard = 0;
      iss_kind = k; iss_dst = 3'(d); iss_src1 = 3'(s1); iss_src2 = 3'(s2);
      #1;
      while (!iss_ready && guard < 500) begin
         @(negedge clk); #1; guard++;
      end
      iss_valid = 1'b1;
      @(posedge clk);
      case (k)
         2'd0: model[d] = model[s1] + model[s2];
         2'd1: model[d] = model[s1] - model[s2];
         default: model[d] = model[s1] * model[s2];
      endcase
      @(negedge clk);
      iss_valid = 1'b0;
   endtask

   task automatic drain();
      repeat (60) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic check_regs(input string req);
      logic [63:0] v; logic [3:0] t;
      for (int r = 0; r < 8; r++) begin
         read_reg(r, v, t);
         check(v == model[r] && t == 4'd0, req, $sformatf("reg %0d value", r), v, model[r]);
      end
   endtask

   task automatic t_reset();
      logic [63:0] v; logic [3:0] t;
      for (int r = 0; r < 8; r++) begin
         read_reg(r, v, t);
         check(v == 64'(r) && t == 0, "R1", $sformatf("reset reg %0d", r), v, r);
      end
      check(cdb_valid == 1'b0, "R1", "no broadcast after reset", cdb_valid, 0);
      iss_kind = 2'd0; #1;
      check(iss_ready, "R1", "ready for add", iss_ready, 1);
      iss_kind = 2'd2; #1;
      check(iss_ready, "R1", "ready for mul", iss_ready, 1);
      @(negedge clk);
   endtask

   task automatic t_rename_kinds();
      logic [63:0] v; logic [3:0] t;
      do_issue(2'd0, 1, 2, 3);
      read_reg(1, v, t);
      check(t == 4'd1, "R3", "first add station tag", t, 1);
      drain();
      check_regs("R10");
      do_issue(2'd3, 4, 5, 6);
      read_reg(4, v, t);
      check(t == 4'd4, "R10", "kind 3 on multiplier station", t, 4);
      do_issue(2'd1, 0, 6, 4);
      drain();
      check_regs("R10");
   endtask

   task automatic t_latency();
      int k;
      clear_log();
      do_issue(2'd0, 4, 2, 3);
      k = cyc;
      drain();
      check(last_bc[1] - k == ADD_LAT, "R5", "add broadcast latency", last_bc[1] - k, ADD_LAT);
      clear_log();
      do_issue(2'd2, 1, 2, 3);
      k = cyc;
      do_issue(2'd0, 5, 1, 1);
      drain();
      check(last_bc[4] - k == MUL_LAT, "R5", "mul broadcast latency", last_bc[4] - k, MUL_LAT);
      check(last_bc[1] - last_bc[4] == ADD_LAT + 1, "R5", "dependent waits for operand",
            last_bc[1] - last_bc[4], ADD_LAT + 1);
      check_regs("R5");
   endtask

   task automatic t_stall();
      logic [63:0] v; logic [3:0] t;
      do_issue(2'd2, 1, 2, 3);
      do_issue(2'd2, 5, 1, 1);
      iss_kind = 2'd2; iss_dst = 3'd6; iss_src1 = 3'd2; iss_src2 = 3'd2;
      #1;
      check(!iss_ready, "R2", "mul stations full", iss_ready, 0);
      iss_kind = 2'd1; #1;
      check(iss_ready, "R2", "add stations still free", iss_ready, 1);
      iss_kind = 2'd2; iss_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      iss_valid = 1'b0;
      read_reg(6, v, t);
      check(t == 4'd0, "R2", "refused issue leaves dst unrenamed", t, 0);
      read_reg(5, v, t);
      check(t == 4'd5, "R3", "second mul station tag", t, 5);
      drain();
      check_regs("R2");
   endtask

   task automatic t_hazards();
      do_issue(2'd2, 1, 2, 3);
      do_issue(2'd0, 5, 1, 2);
      do_issue(2'd0, 1, 6, 7);
      do_issue(2'd1, 2, 7, 3);
      do_issue(2'd2, 3, 1, 5);
      do_issue(2'd0, 3, 3, 2);
      drain();
      check_regs("R4");
   endtask

   task automatic t_same_cycle();
      do_issue(2'd0, 3, 1, 2);
      repeat (2) @(posedge clk);
      @(negedge clk);
      check(cdb_valid && cdb_tag == 4'd1, "R7", "producer on bus", cdb_tag, 1);
      iss_kind = 2'd0; iss_dst = 3'd6; iss_src1 = 3'd3; iss_src2 = 3'd3;
      iss_valid = 1'b1;
      @(posedge clk);
      model[6] = model[3] + model[3];
      @(negedge clk);
      iss_valid = 1'b0;
      drain();
      check_regs("R7");
   endtask

   task automatic t_arb();
      int k;
      clear_log();
      do_issue(2'd2, 4, 2, 3);
      k = cyc;
      @(posedge clk);
      @(negedge clk);
      do_issue(2'd0, 5, 1, 2);
      do_issue(2'd0, 6, 2, 2);
      drain();
      check(last_bc[1] == k + 4, "R9", "tie goes to adder", last_bc[1] - k, 4);
      check(last_bc[4] == k + 5, "R9", "waiting mul beats fresh add", last_bc[4] - k, 5);
      check(last_bc[2] == k + 6, "R9", "younger add broadcast last", last_bc[2] - k, 6);
      check_regs("R9");
   endtask

   task automatic t_wide();
      for (int i = 0; i < 5; i++) do_issue(2'd2, 7, 7, 7);
      do_issue(2'd1, 0, 0, 7);
      drain();
      check_regs("R6");
   endtask

   task automatic t_reuse();
      logic [63:0] v; logic [3:0] t;
      do_issue(2'd2, 7, 7, 2);
      do_issue(2'd0, 1, 7, 1);
      do_issue(2'd0, 2, 7, 2);
      do_issue(2'd0, 3, 7, 3);
      read_reg(1, v, t); check(t == 4'd1, "R8", "reused tag 1", t, 1);
      read_reg(2, v, t); check(t == 4'd2, "R8", "reused tag 2", t, 2);
      read_reg(3, v, t); check(t == 4'd3, "R8", "reused tag 3", t, 3);
      iss_kind = 2'd0; #1;
      check(!iss_ready, "R8", "all adder stations held", iss_ready, 0);
      drain();
      iss_kind = 2'd0; #1;
      check(iss_ready, "R8", "stations freed after broadcast", iss_ready, 1);
      @(negedge clk);
      check_regs("R8");
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; iss_valid = 1'b0; iss_kind = '0;
      iss_dst = '0; iss_src1 = '0; iss_src2 = '0; rd_addr = '0;
      for (int r = 0; r < 8; r++) model[r] = 64'(r);
      clear_log();
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_rename_kinds();
      t_latency();
      t_stall();
      t_hazards();
      t_same_cycle();
      t_arb();
      t_wide();
      t_reuse();
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule